// File: doc/BRIEF.md
# Fixed-Table Prefix-Code Bit-Serial Encoder

This block turns a stream of 3-bit symbol indices into a serial bit stream using a fixed, skewed prefix code built for a source whose eight symbols occur with probabilities 1/2, 1/4, 1/8, 1/16 and 1/64 for each of the last four. Frequent symbols get short codewords (1 bit) and rare ones get long codewords (6 bits). On this source the mean codeword length is exactly 2 bits, which equals the source entropy. A plain 3-bit fixed-length code would need 3 bits, so the compression ratio is 1.5.

Symbols enter through a valid/ready handshake. Codeword bits leave one per clock, most significant bit first, with a valid flag and a flag that marks the last bit of each codeword. A new symbol is taken in the cycle that the previous codeword's last bit is on the output, so a steady input produces a gap-free bit stream. No codeword is a prefix of another, so a receiver can split the stream without separators. Two running counters hold the number of emitted bits and the number of accepted symbols, so the mean code length can be measured.

Top module: `huff_serial_enc`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `bit_valid` and `bit_last` are 0, `sym_ready` is 1, and both counters read 0.
- R2: Index 0..7 selects codewords `1`, `01`, `001`, `0001`, `000001`, `000000`, `000011`, `000010` respectively (lengths 1, 2, 3, 4, 6, 6, 6, 6), sent leftmost bit first on `bit_out`.
- R3: A symbol accepted at a clock edge (`sym_valid` and `sym_ready` both high) shows its first bit on the very next cycle, and its bits then appear on consecutive cycles, one bit per cycle.
- R4: `bit_last` is high exactly on the final bit of each codeword and only while `bit_valid` is high.
- R5: `sym_ready` is high exactly when the output is idle (`bit_valid` low) or the last bit of a codeword is on the output.
- R6: When a symbol is offered in every cycle, the codewords follow each other with no idle cycle between them.
- R7: `sym_valid` asserted while `sym_ready` is low is ignored: the codeword in progress is unchanged and no extra symbol is emitted or counted.
- R8: `total_bits` increases by one for every cycle in which `bit_valid` is high.
- R9: `total_syms` increases by one for every accepted symbol.
- R10: The emitted stream, decoded without separators, reproduces the accepted symbol sequence in order.
- R11: For a block of 64 symbols with 32, 16, 8 and 4 of indices 0..3 and one each of indices 4..7, in any order, exactly 128 bits are emitted (2 bits per symbol).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_valid | input | 1 | Symbol offered |
| sym_idx | input | 3 | Symbol index 0..7 |
| sym_ready | output | 1 | Encoder takes the symbol at this edge |
| bit_valid | output | 1 | `bit_out` carries a code bit |
| bit_out | output | 1 | Serial code bit, leftmost first |
| bit_last | output | 1 | Current bit ends its codeword |
| total_bits | output | 32 | Running count of emitted bits |
| total_syms | output | 32 | Running count of accepted symbols |

## Verification
The bench decodes the serial stream itself and matches each decoded symbol against the send order. A wrong table entry or a shift in the wrong direction shows up as a mismatched or unknown codeword. The hand-over between codewords is timed on back-to-back bursts that mix 1-bit and 6-bit codes. A ready that rises one cycle late would add a gap, and one that rises too early would cut a codeword short. A symbol offered while the encoder is busy must leave the stream and the counters untouched. A design that latched it would insert a spurious codeword. The exact-frequency block checks the 2-bit mean. Any length error in the table would change the 128-bit total.

// File: rtl/huff_pkg.sv
package huff_pkg;
  localparam int SYM_W  = 3;
  localparam int CODE_W = 6;
  localparam int LEN_W  = 3;
  localparam int NSYM   = 1 << SYM_W;

  typedef struct packed {
    logic [CODE_W-1:0] pat;  // left-aligned codeword
    logic [LEN_W-1:0]  len;  // number of valid bits
  } code_ent_t;

  function automatic code_ent_t code_of(input logic [SYM_W-1:0] s);
    code_ent_t e;
    case (s)
      3'd0:    begin e.pat = 6'b100000; e.len = 3'd1; end
      3'd1:    begin e.pat = 6'b010000; e.len = 3'd2; end
      3'd2:    begin e.pat = 6'b001000; e.len = 3'd3; end
      3'd3:    begin e.pat = 6'b000100; e.len = 3'd4; end
      3'd4:    begin e.pat = 6'b000001; e.len = 3'd6; end
      3'd5:    begin e.pat = 6'b000000; e.len = 3'd6; end
      3'd6:    begin e.pat = 6'b000011; e.len = 3'd6; end
      default: begin e.pat = 6'b000010; e.len = 3'd6; end
    endcase
    return e;
  endfunction
endpackage

// File: rtl/huff_code_rom.sv
module huff_code_rom
  import huff_pkg::*;
(
  input  logic [SYM_W-1:0] idx,
  output code_ent_t        ent
);
  code_ent_t rom [NSYM];

  for (genvar g = 0; g < NSYM; g++) begin : g_ent
    assign rom[g] = code_of(SYM_W'(g));
  end

  assign ent = rom[idx];
endmodule

// File: rtl/huff_shifter.sv
module huff_shifter
  import huff_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      load,
  input  code_ent_t ent,
  output logic      ready,
  output logic      bit_valid,
  output logic      bit_out,
  output logic      bit_last
);
  logic [CODE_W-1:0] sh_q;
  logic [LEN_W-1:0]  rem_q;   // bits left including the one on the output
  logic              v_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      rem_q  <= '0;
      v_q    <= 1'b0;
      last_q <= 1'b0;
    end else if (load) begin
      sh_q   <= ent.pat;
      rem_q  <= ent.len;
      v_q    <= 1'b1;
      last_q <= (ent.len == LEN_W'(1));
    end else if (v_q) begin
      sh_q   <= {sh_q[CODE_W-2:0], 1'b0};
      rem_q  <= rem_q - LEN_W'(1);
      v_q    <= (rem_q != LEN_W'(1));
      last_q <= (rem_q == LEN_W'(2));
    end
  end

  assign ready     = !v_q || last_q;
  assign bit_valid = v_q;
  assign bit_out   = sh_q[CODE_W-1];
  assign bit_last  = last_q;
endmodule

// File: rtl/huff_tally.sv
module huff_tally #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (inc) cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/huff_serial_enc.sv
module huff_serial_enc
  import huff_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sym_valid,
  input  logic [SYM_W-1:0] sym_idx,
  output logic             sym_ready,
  output logic             bit_valid,
  output logic             bit_out,
  output logic             bit_last,
  output logic [CNT_W-1:0] total_bits,
  output logic [CNT_W-1:0] total_syms
);
  code_ent_t ent;
  logic      take;

  assign take = sym_valid && sym_ready;

  huff_code_rom u_rom (.idx(sym_idx), .ent(ent));

  huff_shifter u_sh (
    .clk(clk), .rst(rst), .load(take), .ent(ent),
    .ready(sym_ready), .bit_valid(bit_valid),
    .bit_out(bit_out), .bit_last(bit_last)
  );

  huff_tally #(.CNT_W(CNT_W)) u_bits (
    .clk(clk), .rst(rst), .inc(bit_valid), .cnt(total_bits)
  );

  huff_tally #(.CNT_W(CNT_W)) u_syms (
    .clk(clk), .rst(rst), .inc(take), .cnt(total_syms)
  );
endmodule

// File: rtl/huff_serial_enc_chk.sv
module huff_serial_enc_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             sym_valid,
  input logic             sym_ready,
  input logic             bit_valid,
  input logic             bit_last,
  input logic [CNT_W-1:0] total_bits,
  input logic [CNT_W-1:0] total_syms
);
  assert_last_in_valid_R4: assert property (@(posedge clk) disable iff (rst)
    bit_last |-> bit_valid);

  assert_busy_not_ready_R5: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && !bit_last) |-> !sym_ready);

  assert_first_bit_next_R3: assert property (@(posedge clk) disable iff (rst)
    (sym_valid && sym_ready) |=> bit_valid);

  assert_no_gap_inside_R6: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && !bit_last) |=> bit_valid);

  assert_bit_count_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> total_bits == $past(total_bits) + CNT_W'($past(bit_valid)));

  assert_sym_count_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> total_syms == $past(total_syms) + CNT_W'($past(sym_valid && sym_ready)));
endmodule

bind huff_serial_enc huff_serial_enc_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_ready(sym_ready),
  .bit_valid(bit_valid), .bit_last(bit_last),
  .total_bits(total_bits), .total_syms(total_syms)
);

// File: tb/tb_huff_serial_enc.sv
module tb_huff_serial_enc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sym_valid = 1'b0;
  logic [2:0]  sym_idx = '0;
  logic        sym_ready, bit_valid, bit_out, bit_last;
  logic [31:0] total_bits, total_syms;

  always #2.5 clk = ~clk;

  huff_serial_enc dut (
    .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_idx(sym_idx),
    .sym_ready(sym_ready), .bit_valid(bit_valid), .bit_out(bit_out),
    .bit_last(bit_last), .total_bits(total_bits), .total_syms(total_syms)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int expq[$];
  int sent_bits = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // R2 table as the bench reads it
  function automatic int exp_len(int s);
    case (s)
      0: return 1; 1: return 2; 2: return 3; 3: return 4;
      default: return 6;
    endcase
  endfunction

  function automatic logic [5:0] exp_pat(int s);
    case (s)
      0: return 6'b000001; 1: return 6'b000001; 2: return 6'b000001;
      3: return 6'b000001; 4: return 6'b000001; 5: return 6'b000000;
      6: return 6'b000011; default: return 6'b000010;
    endcase
  endfunction  // right-aligned value of the codeword

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // decoding monitor
  logic [5:0] acc = '0;
  int         nb = 0;
  int         found;
  int         want;
  bit         mon_ready_chk = 1'b1;

  always @(negedge clk) begin
    if (!rst) begin
      if (mon_ready_chk)
        chk(sym_ready == (!bit_valid || bit_last), "R5 ready", sym_ready, !bit_valid || bit_last);
      if (bit_valid) begin
        acc = {acc[4:0], bit_out};
        nb++;
        found = -1;
        for (int j = 0; j < 8; j++)
          if (exp_len(j) == nb && exp_pat(j) == acc) found = j;
        if (found >= 0) begin
          chk(bit_last, "R4 last on final bit", bit_last, 1);
          if (expq.size() == 0) begin
            chk(1'b0, "R7 unexpected codeword", found, -1);
          end else begin
            want = expq.pop_front();
            chk(found == want, "R10/R2 decoded symbol", found, want);
          end
          acc = '0;
          nb = 0;
        end else begin
          chk(!bit_last, "R4 early last", bit_last, 0);
          if (nb >= 6) begin
            chk(1'b0, "R2 unknown codeword", acc, -1);
            acc = '0;
            nb = 0;
          end
        end
      end
    end
  end

  // called at a negedge; returns at the negedge after acceptance
  task automatic send(input int s);
    sym_valid = 1'b1;
    sym_idx   = 3'(s);
    expq.push_back(s);
    sent_bits += exp_len(s);
    while (!sym_ready) @(negedge clk);
    @(negedge clk);
    sym_valid = 1'b0;
  endtask

  task automatic drain();
    while (bit_valid || expq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic int pick_sym(int r);
    if (r < 32) return 0;
    if (r < 48) return 1;
    if (r < 56) return 2;
    if (r < 60) return 3;
    return 4 + (r - 60);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int t0, b0, s0, sum;
    int blk[64];
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!bit_valid && sym_ready, "R1 in reset", {bit_valid, sym_ready}, 1);
    rst = 1'b0;
    @(negedge clk);
    chk(!bit_valid && !bit_last && sym_ready, "R1 after reset", {bit_valid, bit_last, sym_ready}, 1);
    chk(total_bits == 0 && total_syms == 0, "R1 counters", total_bits + total_syms, 0);

    // R2 / R3: each symbol alone from idle
    for (int s = 0; s < 8; s++) begin
      t0 = cyc; b0 = total_bits;
      send(s);
      while (bit_valid) @(negedge clk);
      chk(cyc - t0 == exp_len(s) + 1, "R3 single symbol timing", cyc - t0, exp_len(s) + 1);
      chk(total_bits - b0 == exp_len(s), "R8 bits per symbol", total_bits - b0, exp_len(s));
    end

    // R6: back-to-back burst mixing short and long codes
    begin
      int burst[10] = '{0, 0, 4, 0, 7, 1, 3, 6, 5, 2};
      t0 = cyc; sum = 0;
      foreach (burst[i]) begin send(burst[i]); sum += exp_len(burst[i]); end
      while (bit_valid) @(negedge clk);
      chk(cyc - t0 == sum + 1, "R6 gap-free burst", cyc - t0, sum + 1);
    end

    // R7: offer while busy is ignored
    b0 = total_bits; s0 = total_syms;
    send(5);
    chk(!sym_ready, "R7 busy precondition", sym_ready, 0);
    sym_valid = 1'b1; sym_idx = 3'd0;
    @(negedge clk);
    sym_valid = 1'b0;
    drain();
    chk(total_syms - s0 == 1, "R7 no extra symbol", total_syms - s0, 1);
    chk(total_bits - b0 == 6, "R7 codeword unchanged", total_bits - b0, 6);

    // random stream with the source probabilities and random gaps
    b0 = total_bits; s0 = total_syms; sent_bits = 0;
    for (int k = 0; k < 400; k++) begin
      send(pick_sym(int'($urandom % 64)));
      if ($urandom % 4 == 0) repeat ($urandom % 5) @(negedge clk);
    end
    drain();
    chk(total_bits - b0 == sent_bits, "R8 random bit total", total_bits - b0, sent_bits);
    chk(total_syms - s0 == 400, "R9 random symbol total", total_syms - s0, 400);

    // R11: exact-frequency block, shuffled, back-to-back
    for (int i = 0; i < 64; i++)
      blk[i] = (i < 32) ? 0 : (i < 48) ? 1 : (i < 56) ? 2 : (i < 60) ? 3 : 4 + (i - 60);
    for (int i = 63; i > 0; i--) begin
      int j, tmp;
      j = int'($urandom % (i + 1));
      tmp = blk[i]; blk[i] = blk[j]; blk[j] = tmp;
    end
    b0 = total_bits; s0 = total_syms;
    foreach (blk[i]) send(blk[i]);
    drain();
    chk(total_bits - b0 == 128, "R11 block bits", total_bits - b0, 128);
    chk(total_syms - s0 == 64, "R11 block symbols", total_syms - s0, 64);
    chk(expq.size() == 0, "R10 all decoded", expq.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule